// File: doc/BRIEF.md
# Free-Running Cycle Counter with Compare Interrupt

This block keeps a free-running cycle counter for one processor and pairs it with a write-only compare register. Both sit behind one register address. A read at that address returns the live counter value. A write at that address loads the compare register. The counter advances by one on every clock. When the counter's low `CMP_W` bits equal the compare register, a pending flag is set. The pending flag is driven out as an interrupt unless it is masked.

Software arms the next tick by reading the counter, adding an interval, and writing the sum back. Only the low bits take part in the comparison. A value that already lies behind the counter therefore does not fire until those low bits wrap round and reach it again. Each instance runs from its own clock and has no link to any other instance.

`CNT_W` selects the counter width: 64 by default, and 32 is the narrow variant. `CMP_W` sets the compare width, 32 by default.

Top module: `itc_interval_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter clears to zero, the compare register loads all ones, and the pending flag clears. The cycle after reset shows `rd_data` = 0 and `irq` = 0.
- R2: After reset, the counter rises by exactly one at every clock edge and wraps modulo 2^`CNT_W`.
- R3: `rd_data` always shows the present counter value. A write, or `acc_en` itself, never changes what `rd_data` returns.
- R4: The compare register loads `wr_data` at a clock edge only when both `acc_en` = 1 and `acc_we` = 1. With either signal at 0, `wr_data` is ignored.
- R5: The pending flag is set at the clock edge that ends a cycle in which `rd_data[CMP_W-1:0]` equals the compare register. As a result, `irq` (when unmasked) goes high in the cycle where `rd_data[CMP_W-1:0]` equals the compare value plus one.
- R6: Only the low `CMP_W` counter bits take part in the comparison. The same compare value matches again on every 2^`CMP_W`-cycle period, whatever the upper counter bits hold.
- R7: A compare value written behind the counter's low bits does not fire until those bits wrap. The first `irq` comes more than 2^`CMP_W` − 16 cycles later, when writing 5 behind.
- R8: The pending flag stays set until an edge with `irq_ack` = 1 and no match in the same cycle. That edge clears it.
- R9: If `irq_ack` = 1 in a matching cycle, the match wins and the pending flag is set after that edge.
- R10: `irq` = pending AND NOT `irq_mask` (`irq_mask` = 1 blocks). Masking does not clear the pending flag, so a match seen while masked shows up once the mask drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access strobe for the shared address |
| acc_we | input | 1 | 1 = write access (loads compare), 0 = read |
| wr_data | input | CMP_W | Compare value to load |
| rd_data | output | CNT_W | Live counter value |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| irq_ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with a 16-bit counter and a 12-bit compare so that full low-bit wraps fit in the run. It checks every cycle against an arithmetic model of the counter, the compare register and the pending flag. The stimulus covers these cases:
- The reset compare value of all ones.
- A sweep of compare values just ahead of the counter, which separates off-by-one errors in the match timing.
- A value set behind the counter, which separates a true low-bit equality from a greater-or-equal test.
- Writes with only one of the two strobes set, which must leave the compare unchanged.
- A match while masked, which tells gating apart from clearing.
- An acknowledge held across a match, which tells apart the two possible priorities.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int unsigned ITC_CNT_W_DEF = 64;
    localparam int unsigned ITC_CMP_W_DEF = 32;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b11
    } acc_kind_e;

    typedef enum logic {
        PEND_CLEAR = 1'b0,
        PEND_SET   = 1'b1
    } pend_state_e;

    typedef struct packed {
        logic en;
        logic we;
    } acc_req_t;

    function automatic acc_kind_e decode_access(acc_req_t req);
        if (!req.en)     return ACC_IDLE;
        else if (req.we) return ACC_WRITE;
        else             return ACC_READ;
    endfunction

    function automatic pend_state_e next_pending(pend_state_e cur, logic hit, logic ack);
        if (hit)      return PEND_SET;
        else if (ack) return PEND_CLEAR;
        else          return cur;
    endfunction

endpackage

// File: rtl/itc_counter.sv
module itc_counter #(
    parameter int unsigned CNT_W = itc_pkg::ITC_CNT_W_DEF,
    parameter int unsigned CMP_W = itc_pkg::ITC_CMP_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic [CMP_W-1:0] cnt_low
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + ONE;
    end

    assign cnt = cnt_q;

    generate
        if (CNT_W == CMP_W) begin : g_same
            assign cnt_low = cnt_q;
        end else begin : g_slice
            assign cnt_low = cnt_q[CMP_W-1:0];
        end
    endgenerate

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_q == $past(cnt_q) + ONE);
    a_r1_zero: assert property (@(posedge clk)
        rst |=> cnt_q == '0);
endmodule

// File: rtl/itc_compare.sv
module itc_compare #(
    parameter int unsigned CMP_W = itc_pkg::ITC_CMP_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  itc_pkg::acc_req_t req,
    input  logic [CMP_W-1:0] wdata,
    input  logic [CMP_W-1:0] cnt_low,
    output logic             hit
);
    import itc_pkg::*;

    logic [CMP_W-1:0] cmp_q;
    logic             load;

    assign load = (decode_access(req) == ACC_WRITE);

    always_ff @(posedge clk) begin
        if (rst)       cmp_q <= '1;
        else if (load) cmp_q <= wdata;
    end

    assign hit = (cnt_low == cmp_q);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.we) |=> cmp_q == $past(wdata));
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !(req.en && req.we) |=> $stable(cmp_q));
endmodule

// File: rtl/itc_irq_ctl.sv
module itc_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic ack,
    input  logic mask,
    output logic irq
);
    import itc_pkg::*;

    pend_state_e pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= PEND_CLEAR;
        else     pend_q <= next_pending(pend_q, hit, ack);
    end

    assign irq = (pend_q == PEND_SET) && !mask;

    a_r5_set: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_q == PEND_SET);
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend_q == PEND_SET && !ack) |=> pend_q == PEND_SET);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> pend_q == PEND_CLEAR);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (pend_q == PEND_CLEAR && !hit) |=> pend_q == PEND_CLEAR);
endmodule

// File: rtl/itc_interval_timer.sv
module itc_interval_timer #(
    parameter int unsigned CNT_W = itc_pkg::ITC_CNT_W_DEF,
    parameter int unsigned CMP_W = itc_pkg::ITC_CMP_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [CMP_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_mask,
    input  logic             irq_ack,
    output logic             irq
);
    import itc_pkg::*;

    acc_req_t         req;
    logic [CMP_W-1:0] cnt_low;
    logic             hit;

    assign req.en = acc_en;
    assign req.we = acc_we;

    initial begin
        if (CNT_W < CMP_W) $error("itc_interval_timer: CNT_W must be >= CMP_W");
    end

    itc_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cnt     (rd_data),
        .cnt_low (cnt_low)
    );

    itc_compare #(.CMP_W(CMP_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (wr_data),
        .cnt_low (cnt_low),
        .hit     (hit)
    );

    itc_irq_ctl u_irq (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .ack  (irq_ack),
        .mask (irq_mask),
        .irq  (irq)
    );

    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        irq_mask |-> !irq);
endmodule

// File: tb/itc_interval_timer_tb.sv
module itc_interval_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int CMP_W = 12;
    localparam int MOD = 1 << CMP_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_en = 1'b0, acc_we = 1'b0, irq_mask = 1'b0, irq_ack = 1'b0;
    logic [CMP_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic irq;

    int vectors = 0, errors = 0, cycles = 0;
    bit done = 0;

    logic [CNT_W-1:0] m_cnt = '0;
    logic [CMP_W-1:0] m_cmp = '1;
    logic m_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    itc_interval_timer #(.CNT_W(CNT_W), .CMP_W(CMP_W)) dut_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .wr_data(wr_data), .rd_data(rd_data), .irq_mask(irq_mask),
        .irq_ack(irq_ack), .irq(irq));

    // reference model from R1, R2, R4, R5, R8, R9
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_cmp <= '1; m_pend <= 1'b0;
        end else begin
            m_cnt <= m_cnt + 1'b1;
            if (acc_en && acc_we) m_cmp <= wr_data;
            if (m_cnt[CMP_W-1:0] == m_cmp) m_pend <= 1'b1;
            else if (irq_ack)              m_pend <= 1'b0;
        end
        cycles++;
    end

    task automatic check(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison (R2, R3, R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2/R3 counter", rd_data, m_cnt);
            check("R10 irq", irq, m_pend & ~irq_mask);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
        end
    endtask

    task automatic wr(logic en, logic we, logic [CMP_W-1:0] v);
        acc_en = en; acc_we = we; wr_data = v;
        step(1);
        acc_en = 0; acc_we = 0;
    endtask

    task automatic ack1();
        irq_ack = 1; step(1); irq_ack = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        logic [CMP_W-1:0] x;
        int wait_n;
        step(3);
        // R1: reset state
        check("R1 rd_data in reset", rd_data, 0);
        check("R1 irq in reset", irq, 0);
        rst = 0;
        step(1);
        check("R1 counter after reset", rd_data, 1);
        // R5/R1: default all-ones compare matches at low bits 4095
        step(MOD + 2);
        check("R5 default compare fired", irq, 1);
        // R8: sticky
        step(5);
        check("R8 sticky pending", irq, 1);
        ack1();
        check("R8 ack clears", irq, 0);
        // R6: same compare fires again each low-bit period
        step(MOD - 6);
        check("R6 refire after period", irq, 1);
        ack1();
        // R5 sweep of compare values ahead of the counter
        for (int k = 0; k < 8; k++) begin
            x = rd_data[CMP_W-1:0] + CMP_W'(3 + k * 37);
            wr(1, 1, x);
            wait_n = 0;
            while (!irq && wait_n < 400) begin step(1); wait_n++; end
            check("R5 fire low bits == cmp+1", rd_data[CMP_W-1:0], x + 1'b1);
            ack1();
        end
        // R4: ignored writes (one strobe only) leave compare alone
        x = rd_data[CMP_W-1:0] + CMP_W'(10);
        wr(0, 1, x);
        wr(1, 0, x);
        step(20);
        check("R4 ignored write no fire", irq, 0);
        // R7: compare behind counter waits for wrap
        x = rd_data[CMP_W-1:0] - CMP_W'(5);
        wr(1, 1, x);
        wait_n = 0;
        while (!irq && wait_n < MOD + 50) begin step(1); wait_n++; end
        check("R7 wait exceeds wrap threshold", (wait_n > MOD - 16), 1);
        check("R7 fire position", rd_data[CMP_W-1:0], x + 1'b1);
        ack1();
        // R10: match while masked, then unmask
        irq_mask = 1;
        x = rd_data[CMP_W-1:0] + CMP_W'(8);
        wr(1, 1, x);
        step(15);
        check("R10 masked irq low", irq, 0);
        irq_mask = 0;
        step(1);
        check("R10 pending visible after unmask", irq, 1);
        ack1();
        // R9: ack held across a match, match wins for one cycle
        x = rd_data[CMP_W-1:0] + CMP_W'(6);
        wr(1, 1, x);
        irq_ack = 1;
        wait_n = 0;
        while (!irq && wait_n < 30) begin step(1); wait_n++; end
        check("R9 match beats ack", irq, 1);
        step(1);
        check("R9 held ack then clears", irq, 0);
        irq_ack = 0;
        step(5);
        finish_run();
    end
endmodule